// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This controller turns single-beat read and write requests from a processor-side port into the strobe sequence of an asynchronous DRAM. The DRAM has one address bus for both row and column. Each request carries a flat address that is split into three parts: a column, a row and a chip index. The chip index selects one of several active-low chip selects. The row goes onto the shared bus under the row strobe. After the row-to-column delay, the column follows under the column strobe. Read data is captured a fixed number of cycles after the column strobe and is returned with a one-cycle valid pulse. All delays are parameters counted in clock cycles.

After an access the row stays open. A later request to the same chip and row issues only a column strobe. A request to any other row first closes the open row for the precharge time. An internal timer requests a refresh once per row-retention slot. A pending refresh takes priority over new requests. It closes any open row, then strobes the next refresh row into every chip at once with no column strobe, and then precharges. The request port drops ready until all of that is done.

Top module: `dramc_top`

## Requirements
- R1: The request address is split so that bits 9:0 are the column and bits 19:10 are the row. Bits 23:20 give a chip index n, and on an access only `dram_cs_n[n]` is driven low. During an access, `dram_addr` carries the row while the row strobe falls and the column while the column strobe falls.
- R2: The column strobe `dram_cas_n` is low only while the row strobe `dram_ras_n` is also low. The row is always placed on the bus before the column.
- R3: On an access that opens a row, `dram_cas_n` falls exactly T_RCD cycles after `dram_ras_n` falls.
- R4: A read captures `dram_dq_in` T_CL cycles after `dram_cas_n` falls. In that cycle `rd_valid` is high for exactly one cycle and `rd_data` holds the data at the requested address.
- R5: Before any row is opened, `dram_ras_n` has been high for at least T_RP cycles.
- R6: A request to the chip and row that are already open produces no new row-strobe fall. A request to another row or another chip produces exactly one row-strobe fall.
- R7: Every REF_CYC = CLK_MHZ*RETENTION_US/2^ROW_W cycles (within a bounded slack), a refresh takes place. During a refresh all chip selects are low and `dram_ras_n` is low for T_RAS cycles, with no column strobe. The refresh row appears on `dram_addr`; it starts at 0 and increases by one for each refresh, wrapping at 2^ROW_W.
- R8: Whenever a refresh row strobe is low, `req_ready` is low. An open row is closed with at least T_RP cycles of precharge before the refresh. Once a refresh has taken place, the next access to the previously open row opens it again.
- R9: After reset, all strobes, `dram_we_n` and all chip selects are high, `dram_dq_oe` is low, `rd_valid` is low and `req_ready` is high.
- R10: On a write, `dram_we_n` is low only while `dram_cas_n` is low. `dram_dq_oe` is high and `dram_dq_out` equals the request's write data when the column strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | CS_W+ROW_W+COL_W | Flat request address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| rd_data | output | DW | Read data |
| dram_cs_n | output | 2^CS_W | Active-low chip selects |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_dq_out | output | DW | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DW | Data from the DRAM |

## Verification
The assertions check the following on every cycle:
- The column strobe is nested inside the row strobe, and write enable is nested inside the column strobe.
- The minimum row-to-column and precharge spacings hold.
- The chip-select pattern is either one chip or all chips.
- There is no column strobe and no ready during a refresh.
- Read valid is a single pulse.
- The refresh deadline is met.

Some behaviour can only be shown by the bench's scenarios, which run against a behavioural DRAM model:
- the exact delays,
- correct data after page hits and misses,
- the row and column values on the shared bus,
- the refresh row sequence,
- and the reopening of a row that a refresh has closed.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_REF,
    ST_RFP
  } dramc_state_e;
endpackage

// File: rtl/dramc_addr_split.sv
module dramc_addr_split #(
  parameter int COL_W = 10,
  parameter int ROW_W = 10,
  parameter int CS_W  = 4,
  localparam int AW   = CS_W + ROW_W + COL_W,
  localparam int NCS  = 2 ** CS_W
) (
  input  logic [AW-1:0]    addr,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic [CS_W-1:0]  sel,
  output logic [NCS-1:0]   sel_n
);
  assign col = addr[COL_W-1:0];
  assign row = addr[COL_W +: ROW_W];
  assign sel = addr[COL_W+ROW_W +: CS_W];

  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign sel_n[g] = (sel != CS_W'(g));
  end
endmodule

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
  parameter int REF_CYC = 200,
  parameter int ROW_W   = 10,
  localparam int TW     = $clog2(REF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_take,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  logic [TW-1:0] tick;
  logic          wrap;

  assign wrap = (tick == TW'(REF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick     <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tick <= wrap ? '0 : tick + 1'b1;
      if (ref_take) begin
        ref_pend <= 1'b0;
        ref_row  <= ref_row + 1'b1;
      end
      if (wrap) ref_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 10,
  parameter int CS_W  = 4,
  parameter int DW    = 8,
  parameter int T_RCD = 3,
  parameter int T_CL  = 2,
  parameter int T_RP  = 2,
  parameter int T_RAS = 3,
  localparam int NCS  = 2 ** CS_W,
  localparam int BW   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int TMX1 = (T_RCD > T_CL) ? T_RCD : T_CL,
  localparam int TMX2 = (T_RP > T_RAS) ? T_RP : T_RAS,
  localparam int TMAX = (TMX1 > TMX2) ? TMX1 : TMX2,
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [DW-1:0]    req_wdata,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [CS_W-1:0]  req_sel,
  input  logic [NCS-1:0]   req_sel_n,
  input  logic             ref_pend,
  input  logic [ROW_W-1:0] ref_row,
  output logic             ref_take,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [NCS-1:0]   dram_cs_n,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [BW-1:0]    dram_addr,
  output logic [DW-1:0]    dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [DW-1:0]    dram_dq_in
);
  dramc_state_e     st;
  logic [CW-1:0]    cnt;
  logic [COL_W-1:0] a_col;
  logic [ROW_W-1:0] a_row;
  logic [CS_W-1:0]  a_sel;
  logic [NCS-1:0]   a_sel_n;
  logic             a_we;
  logic [DW-1:0]    a_data;
  logic             pre_to_ref;
  logic             page_hit;
  logic             accept;

  assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_pend;
  assign accept    = req_ready && req_valid;
  assign page_hit  = (req_row == a_row) && (req_sel == a_sel);
  assign ref_take  = ((st == ST_IDLE) && ref_pend) ||
                     ((st == ST_PRE) && (cnt == '0) && pre_to_ref);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_cs_n   <= '1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      a_col       <= '0;
      a_row       <= '0;
      a_sel       <= '0;
      a_sel_n     <= '1;
      a_we        <= 1'b0;
      a_data      <= '0;
      pre_to_ref  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        a_col   <= req_col;
        a_row   <= req_row;
        a_sel   <= req_sel;
        a_sel_n <= req_sel_n;
        a_we    <= req_we;
        a_data  <= req_wdata;
      end
      if (ref_take) begin
        dram_ras_n <= 1'b0;
        dram_cs_n  <= '0;
        dram_addr  <= BW'(ref_row);
        cnt        <= CW'(T_RAS - 1);
        st         <= ST_REF;
      end else begin
        unique case (st)
          ST_IDLE: if (accept) begin
            dram_ras_n <= 1'b0;
            dram_cs_n  <= req_sel_n;
            dram_addr  <= BW'(req_row);
            cnt        <= CW'(T_RCD - 1);
            st         <= ST_RCD;
          end
          ST_RCD: if (cnt == '0) begin
            dram_cas_n  <= 1'b0;
            dram_addr   <= BW'(a_col);
            dram_we_n   <= ~a_we;
            dram_dq_oe  <= a_we;
            dram_dq_out <= a_data;
            cnt         <= CW'(T_CL - 1);
            st          <= ST_CAS;
          end else cnt <= cnt - 1'b1;
          ST_CAS: if (cnt == '0) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!a_we) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            st <= ST_OPEN;
          end else cnt <= cnt - 1'b1;
          ST_OPEN: if (ref_pend) begin
            dram_ras_n <= 1'b1;
            pre_to_ref <= 1'b1;
            cnt        <= CW'(T_RP - 1);
            st         <= ST_PRE;
          end else if (accept) begin
            if (page_hit) begin
              dram_cas_n  <= 1'b0;
              dram_addr   <= BW'(req_col);
              dram_we_n   <= ~req_we;
              dram_dq_oe  <= req_we;
              dram_dq_out <= req_wdata;
              cnt         <= CW'(T_CL - 1);
              st          <= ST_CAS;
            end else begin
              dram_ras_n <= 1'b1;
              pre_to_ref <= 1'b0;
              cnt        <= CW'(T_RP - 1);
              st         <= ST_PRE;
            end
          end
          ST_PRE: if (cnt == '0) begin
            dram_ras_n <= 1'b0;
            dram_cs_n  <= a_sel_n;
            dram_addr  <= BW'(a_row);
            cnt        <= CW'(T_RCD - 1);
            st         <= ST_RCD;
          end else cnt <= cnt - 1'b1;
          ST_REF: if (cnt == '0) begin
            dram_ras_n <= 1'b1;
            dram_cs_n  <= '1;
            cnt        <= CW'(T_RP - 1);
            st         <= ST_RFP;
          end else cnt <= cnt - 1'b1;
          ST_RFP: if (cnt == '0) st <= ST_IDLE;
                  else cnt <= cnt - 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int COL_W        = 10,
  parameter int ROW_W        = 10,
  parameter int CS_W         = 4,
  parameter int DW           = 8,
  parameter int T_RCD        = 3,
  parameter int T_CL         = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 3,
  parameter int CLK_MHZ      = 200,
  parameter int RETENTION_US = 64000,
  localparam int AW          = CS_W + ROW_W + COL_W,
  localparam int NCS         = 2 ** CS_W,
  localparam int BW          = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int REF_CYC     = (CLK_MHZ * RETENTION_US) / (2 ** ROW_W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic [NCS-1:0] dram_cs_n,
  output logic           dram_ras_n,
  output logic           dram_cas_n,
  output logic           dram_we_n,
  output logic [BW-1:0]  dram_addr,
  output logic [DW-1:0]  dram_dq_out,
  output logic           dram_dq_oe,
  input  logic [DW-1:0]  dram_dq_in
);
  logic [COL_W-1:0] s_col;
  logic [ROW_W-1:0] s_row;
  logic [CS_W-1:0]  s_sel;
  logic [NCS-1:0]   s_sel_n;
  logic             ref_pend;
  logic             ref_take;
  logic [ROW_W-1:0] ref_row;

  dramc_addr_split #(.COL_W(COL_W), .ROW_W(ROW_W), .CS_W(CS_W)) u_split (
    .addr(req_addr), .col(s_col), .row(s_row), .sel(s_sel), .sel_n(s_sel_n)
  );

  dramc_refresh_timer #(.REF_CYC(REF_CYC), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst(rst), .ref_take(ref_take), .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dramc_seq #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CS_W(CS_W), .DW(DW),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_wdata(req_wdata),
    .req_col(s_col), .req_row(s_row), .req_sel(s_sel), .req_sel_n(s_sel_n),
    .ref_pend(ref_pend), .ref_row(ref_row), .ref_take(ref_take),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );
endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
  parameter int NCS     = 16,
  parameter int T_RCD   = 3,
  parameter int T_CL    = 2,
  parameter int T_RP    = 2,
  parameter int T_RAS   = 3,
  parameter int REF_CYC = 200,
  localparam int SLACK  = 2 * T_RP + T_RCD + T_CL + T_RAS + 8,
  localparam int LW     = $clog2(T_RCD + T_RP + 2),
  localparam int DWIN   = $clog2(REF_CYC + SLACK + 2)
) (
  input logic           clk,
  input logic           rst,
  input logic           ras_n,
  input logic           cas_n,
  input logic           we_n,
  input logic [NCS-1:0] cs_n,
  input logic           rd_valid,
  input logic           req_ready
);
  logic [LW-1:0]   low_cnt;
  logic [LW-1:0]   high_cnt;
  logic [DWIN-1:0] since_ref;
  logic            prev_ras_n;
  logic            ref_start;

  assign ref_start = prev_ras_n && !ras_n && (cs_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      high_cnt   <= LW'(T_RP);
      since_ref  <= '0;
      prev_ras_n <= 1'b1;
    end else begin
      prev_ras_n <= ras_n;
      if (ras_n) low_cnt <= '0;
      else if (low_cnt < LW'(T_RCD)) low_cnt <= low_cnt + 1'b1;
      if (!ras_n) high_cnt <= '0;
      else if (high_cnt < LW'(T_RP)) high_cnt <= high_cnt + 1'b1;
      if (ref_start) since_ref <= '0;
      else if (since_ref < DWIN'(REF_CYC + SLACK + 1)) since_ref <= since_ref + 1'b1;
    end
  end

  AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n); // R2
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (low_cnt >= LW'(T_RCD))); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4
  AST_TRP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (high_cnt >= LW'(T_RP))); // R5
  AST_CS_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ($countones(~cs_n) <= 1) || (cs_n == '0)); // R1
  AST_NO_CAS_IN_REF: assert property (@(posedge clk) disable iff (rst)
    (cs_n == '0) |-> cas_n); // R7
  AST_REF_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    since_ref <= DWIN'(REF_CYC + SLACK)); // R7
  AST_NO_READY_IN_REF: assert property (@(posedge clk) disable iff (rst)
    (cs_n == '0 && !ras_n) |-> !req_ready); // R8
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !cas_n); // R10
endmodule

bind dramc_top dramc_checker #(
  .NCS(NCS), .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS), .REF_CYC(REF_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .cs_n(dram_cs_n), .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/tb_dramc_top.sv
`timescale 1ns/1ps
module tb_dramc_top;
  localparam int COL_W = 10, ROW_W = 10, CS_W = 4, DW = 8;
  localparam int T_RCD = 3, T_CL = 2, T_RP = 2, T_RAS = 3;
  localparam int CLK_MHZ = 200, RET_US = 1024;
  localparam int REF_CYC = (CLK_MHZ * RET_US) / (2 ** ROW_W);
  localparam int SLACK = 2 * T_RP + T_RCD + T_CL + T_RAS + 8;
  localparam int AW = CS_W + ROW_W + COL_W;
  localparam int NCS = 2 ** CS_W;
  localparam int BW = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [NCS-1:0] dram_cs_n;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [BW-1:0] dram_addr;
  logic [DW-1:0] dram_dq_out, dram_dq_in;

  always #2.5 clk = ~clk;

  dramc_top #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CS_W(CS_W), .DW(DW),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS),
    .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sel_of(input logic [NCS-1:0] cs);
    for (int i = 0; i < NCS; i++) if (!cs[i]) return i;
    return 0;
  endfunction

  function automatic int midx(input int sel, input int row, input int col);
    return ((sel & 3) << 6) | ((row & 3) << 4) | (col & 15);
  endfunction

  // behavioural DRAM model
  logic [DW-1:0] mem [256];
  logic [ROW_W-1:0] mdl_row;
  logic mdl_prev_ras = 1'b1;
  int mdl_cas_cnt = 0;

  always @(posedge clk) begin
    mdl_prev_ras <= dram_ras_n;
    if (mdl_prev_ras && !dram_ras_n) mdl_row <= dram_addr[ROW_W-1:0];
    if (!dram_cas_n) begin
      if (mdl_cas_cnt == 0 && !dram_we_n)
        mem[midx(sel_of(dram_cs_n), int'(mdl_row), int'(dram_addr))] <= dram_dq_out;
      mdl_cas_cnt <= mdl_cas_cnt + 1;
    end else mdl_cas_cnt <= 0;
  end

  assign dram_dq_in = (!dram_cas_n && dram_we_n && mdl_cas_cnt == T_CL - 1) ?
                      mem[midx(sel_of(dram_cs_n), int'(mdl_row), int'(dram_addr))] : 8'hA5;

  // monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int last_rise = -100, last_fall = 0, last_cas = 0, last_ref = 0;
  int act_total = 0, cas_total = 0, rd_total = 0, ref_total = 0;
  int exp_ref_row = 0;
  logic act_in_op = 1'b0;
  int cur_sel, cur_row, cur_col;
  bit cur_we;
  logic [DW-1:0] cur_data, cur_exp;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        if (dram_cs_n == '0) begin
          check(int'(dram_addr) == exp_ref_row, "R7 refresh row", dram_addr, exp_ref_row);
          check(!req_ready, "R8 ready low in refresh", req_ready, 0);
          check(cyc - last_rise >= T_RP, "R8 precharge before refresh", cyc - last_rise, T_RP);
          check(cyc - last_ref <= REF_CYC + SLACK, "R7 refresh interval max", cyc - last_ref, REF_CYC);
          if (ref_total > 0)
            check(cyc - last_ref >= REF_CYC - SLACK, "R7 refresh interval min", cyc - last_ref, REF_CYC);
          exp_ref_row = (exp_ref_row + 1) % (2 ** ROW_W);
          last_ref = cyc;
          ref_total++;
        end else begin
          check(int'(dram_addr) == cur_row, "R1 row on bus", dram_addr, cur_row);
          check(sel_of(dram_cs_n) == cur_sel && $countones(~dram_cs_n) == 1,
                "R1 chip select", sel_of(dram_cs_n), cur_sel);
          check(cyc - last_rise >= T_RP, "R5 precharge", cyc - last_rise, T_RP);
          last_fall = cyc;
          act_in_op = 1'b1;
          act_total++;
        end
      end
      if (!prev_ras && dram_ras_n) last_rise = cyc;
      if (prev_cas && !dram_cas_n) begin
        check(!dram_ras_n, "R2 cas inside ras", dram_ras_n, 0);
        check(dram_cs_n != '0, "R7 no cas in refresh", 0, 1);
        check(int'(dram_addr) == cur_col, "R1 column on bus", dram_addr, cur_col);
        if (act_in_op)
          check(cyc - last_fall == T_RCD, "R3 ras to cas", cyc - last_fall, T_RCD);
        if (cur_we) begin
          check(!dram_we_n && dram_dq_oe, "R10 write strobes", {dram_we_n, dram_dq_oe}, 1);
          check(dram_dq_out == cur_data, "R10 write data", dram_dq_out, cur_data);
        end else
          check(dram_we_n && !dram_dq_oe, "R10 read strobes", {dram_we_n, dram_dq_oe}, 2);
        last_cas = cyc;
        cas_total++;
      end
      if (rd_valid) begin
        check(!cur_we, "R4 no rd_valid on write", 1, 0);
        check(cyc - last_cas == T_CL, "R4 cas latency", cyc - last_cas, T_CL);
        check(rd_data == cur_exp, "R4 read data", rd_data, cur_exp);
        rd_total++;
      end
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  // bench side
  logic [DW-1:0] ref_mem [256];
  bit open_v = 0;
  int open_sel = 0, open_row = 0, open_ref = 0;

  task automatic do_op(input bit we, input int sel, input int row, input int col, input logic [DW-1:0] d);
    int a0, c0, r0, hit;
    while (!req_ready) @(negedge clk);
    hit = (open_v && open_sel == sel && open_row == row && open_ref == ref_total) ? 1 : 0;
    cur_sel = sel; cur_row = row; cur_col = col; cur_we = we; cur_data = d;
    cur_exp = ref_mem[midx(sel, row, col)];
    if (we) ref_mem[midx(sel, row, col)] = d;
    act_in_op = 1'b0;
    a0 = act_total; c0 = cas_total; r0 = rd_total;
    req_valid = 1'b1; req_we = we; req_wdata = d;
    req_addr = {CS_W'(sel), ROW_W'(row), COL_W'(col)};
    @(negedge clk);
    req_valid = 1'b0;
    if (we) while (cas_total == c0) @(negedge clk);
    else while (rd_total == r0) @(negedge clk);
    check(act_total - a0 == (hit ? 0 : 1), hit ? "R6 page hit no activate" : "R6 miss one activate",
          act_total - a0, hit ? 0 : 1);
    open_v = 1; open_sel = sel; open_row = row; open_ref = ref_total;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R9 strobes high", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    check(dram_cs_n == '1, "R9 selects high", dram_cs_n, 16'hFFFF);
    check(!dram_dq_oe && !rd_valid, "R9 outputs quiet", {dram_dq_oe, rd_valid}, 0);
    rst = 1'b0;
    last_ref = cyc;
    @(negedge clk);
    check(req_ready, "R9 ready after reset", req_ready, 1);
    // directed
    do_op(1, 1, 5, 3, 8'h3C);
    do_op(0, 1, 5, 3, 8'h00);
    do_op(1, 1, 5, 7, 8'h81);
    do_op(0, 1, 5, 7, 8'h00);
    do_op(0, 1, 6, 3, 8'h00);
    do_op(1, 2, 6, 3, 8'h5A);
    do_op(0, 2, 6, 3, 8'h00);
    repeat (REF_CYC + 40) @(negedge clk);
    check(ref_total >= 1, "R7 refresh occurred", ref_total, 1);
    do_op(0, 2, 6, 3, 8'h00);   // row closed by refresh: R8 reopen
    // random
    for (int n = 0; n < 150; n++) begin
      int s, r, c;
      s = $urandom_range(0, 3);
      r = $urandom_range(0, 3);
      c = $urandom_range(0, 15);
      do_op(1'($urandom_range(0, 1)), s, r, c, 8'($urandom));
    end
    repeat (2 * REF_CYC) @(negedge clk);
    check(ref_total >= 3, "R7 refresh count", ref_total, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule